// File: doc/BRIEF.md
# Vector Register Bank with Streaming Element ALU

This block holds eight vector registers of eight 16-bit elements each and executes element-wise vector instructions on them. One instruction names an operation, a destination register and two source registers. Once accepted, the block reads one element pair from the two sources on each clock. It passes the pair through a three-stage integer pipeline and writes one result element per clock back through the single write port of the register bank.

Three arithmetic operations are supported: sum, difference (first source minus second) and product. Each keeps the low 16 bits of its result. A fourth operation, equality compare, writes no vector. It builds an 8-bit mask in which bit i reports whether element i of the two sources match. Each written element also appears on a writeback output bus. An element-fill port lets the surrounding logic place values into the bank while the block is idle. A register can be read back by adding the all-zero register to it in place.

Top module: `vec_alu_engine`

## Requirements
- R1: After reset, busy, done and wb_valid are 0, issue_ready is 1, mask_out is 0 and every element of every register is 0.
- R2: While busy is 0, fill_valid high at a rising edge writes fill_data into element fill_idx of register fill_reg.
- R3: Opcode 0 (sum) writes src_a[i] + src_b[i], truncated to 16 bits, into element i of the destination.
- R4: Opcode 1 (difference) writes src_a[i] - src_b[i], modulo 2^16, into element i of the destination.
- R5: Opcode 2 (product) writes the low 16 bits of src_a[i] * src_b[i] into element i of the destination.
- R6: For an arithmetic instruction accepted at edge E, element k (0..7) is shown on wb_valid/wb_idx/wb_data during the cycle after edge E+3+k. The eight elements come on consecutive cycles in increasing index order, and wb_valid is 0 at all other times.
- R7: busy rises at the accepting edge and falls at edge E+11, which writes the last element. done is a one-cycle pulse in the cycle after E+11. issue_ready equals the inverse of busy.
- R8: Opcode 3 (compare) clears mask_out at acceptance and sets mask_out bit i to 1 exactly when src_a[i] equals src_b[i]. The final mask is present when done is high. No register is written and wb_valid stays 0.
- R9: Arithmetic instructions leave mask_out unchanged.
- R10: issue_valid and fill_valid are ignored while busy is 1. No second instruction starts and no element is filled.
- R11: A destination equal to a source register is processed element by element correctly, so each element result uses the element's value from before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction request |
| issue_ready | output | 1 | High when a request will be taken |
| issue_op | input | 2 | 0 sum, 1 difference, 2 product, 3 compare |
| issue_dst | input | 3 | Destination register |
| issue_src_a | input | 3 | First source register |
| issue_src_b | input | 3 | Second source register |
| fill_valid | input | 1 | Element fill request |
| fill_reg | input | 3 | Register to fill |
| fill_idx | input | 3 | Element index to fill |
| fill_data | input | 16 | Fill value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback element present |
| wb_idx | output | 3 | Index of the written element |
| wb_data | output | 16 | Value of the written element |
| mask_out | output | 8 | Compare mask, bit i for element i |

## Verification
The arithmetic operations are applied to vectors that mix sign-boundary values (0x7FFF, 0x8000, 0xFFFF) with small and distinct values. This separates a truncated sum from a carried one, a reversed difference from the right one, and a low product half from a high one. The compare operation runs on a pair with a mixed pattern of equal and unequal elements, and on a register compared with itself, which must give all ones. A cycle-exact record of each writeback distinguishes correct timing from an off-by-one pipeline depth or an element reordering. An instruction whose destination is also a source shows whether elements are read before they are overwritten. Requests arriving mid-instruction show that both the issue and fill paths are blocked.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [1:0] {
    VOP_ADD = 2'd0,
    VOP_SUB = 2'd1,
    VOP_MUL = 2'd2,
    VOP_CMP = 2'd3
  } vop_e;
endpackage

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int NUM_REGS  = 8,
  parameter int NUM_ELEMS = 8,
  parameter int ELEM_W    = 16,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int IDX_W = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ra_reg,
  input  logic [REG_W-1:0]  rb_reg,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [ELEM_W-1:0] ra_data,
  output logic [ELEM_W-1:0] rb_data,
  input  logic              we,
  input  logic [REG_W-1:0]  w_reg,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [ELEM_W-1:0] w_data
);
  logic [ELEM_W-1:0] mem [NUM_REGS][NUM_ELEMS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++)
        for (int e = 0; e < NUM_ELEMS; e++)
          mem[r][e] <= '0;
    end else if (we) begin
      mem[w_reg][w_idx] <= w_data;
    end
  end

  assign ra_data = mem[ra_reg][r_idx];
  assign rb_data = mem[rb_reg][r_idx];
endmodule

// File: rtl/vec_pipe.sv
module vec_pipe
  import vrf_pkg::*;
#(
  parameter int NUM_ELEMS = 8,
  parameter int ELEM_W    = 16,
  localparam int IDX_W = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IDX_W-1:0]  in_idx,
  input  vop_e              in_op,
  input  logic [ELEM_W-1:0] in_a,
  input  logic [ELEM_W-1:0] in_b,
  output logic              out_vld,
  output logic [IDX_W-1:0]  out_idx,
  output vop_e              out_op,
  output logic [ELEM_W-1:0] out_res,
  output logic              out_eq
);
  function automatic logic [ELEM_W-1:0] elem_result(vop_e op, logic [ELEM_W-1:0] a,
                                                    logic [ELEM_W-1:0] b);
    logic [ELEM_W-1:0] r;
    case (op)
      VOP_ADD: r = a + b;
      VOP_SUB: r = a - b;
      VOP_MUL: r = a * b;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic elem_match(logic [ELEM_W-1:0] a, logic [ELEM_W-1:0] b);
    return a == b;
  endfunction

  logic              v1, v2;
  logic [IDX_W-1:0]  i1, i2;
  vop_e              o1, o2;
  logic [ELEM_W-1:0] a1, b1, res2;
  logic              eq2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_vld <= 1'b0;
      i1 <= '0; i2 <= '0; out_idx <= '0;
      o1 <= VOP_ADD; o2 <= VOP_ADD; out_op <= VOP_ADD;
      a1 <= '0; b1 <= '0; res2 <= '0; out_res <= '0;
      eq2 <= 1'b0; out_eq <= 1'b0;
    end else begin
      v1 <= in_vld; i1 <= in_idx; o1 <= in_op; a1 <= in_a; b1 <= in_b;
      v2 <= v1; i2 <= i1; o2 <= o1;
      res2 <= elem_result(o1, a1, b1);
      eq2  <= elem_match(a1, b1);
      out_vld <= v2; out_idx <= i2; out_op <= o2; out_res <= res2; out_eq <= eq2;
    end
  end

  a_r6_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> (v2 && i2 == $past(i1)));
  a_r6_stage_last: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |=> (out_vld && out_idx == $past(i2)));
endmodule

// File: rtl/vec_seq.sv
module vec_seq
  import vrf_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int NUM_ELEMS = 8,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int IDX_W = $clog2(NUM_ELEMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  vop_e             issue_op,
  input  logic [REG_W-1:0] issue_dst,
  input  logic [REG_W-1:0] issue_src_a,
  input  logic [REG_W-1:0] issue_src_b,
  input  logic             wr_last,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic             rd_vld,
  output logic [IDX_W-1:0] rd_idx,
  output vop_e             cur_op,
  output logic [REG_W-1:0] cur_dst,
  output logic [REG_W-1:0] cur_src_a,
  output logic [REG_W-1:0] cur_src_b
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEMS - 1);

  assign accept = issue_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rd_vld <= 1'b0; rd_idx <= '0;
      cur_op <= VOP_ADD; cur_dst <= '0; cur_src_a <= '0; cur_src_b <= '0;
    end else begin
      done <= wr_last;
      if (accept) begin
        busy <= 1'b1; rd_vld <= 1'b1; rd_idx <= '0;
        cur_op <= issue_op; cur_dst <= issue_dst;
        cur_src_a <= issue_src_a; cur_src_b <= issue_src_b;
      end else begin
        if (rd_vld) begin
          rd_idx <= rd_idx + 1'b1;
          if (rd_idx == LAST_IDX) rd_vld <= 1'b0;
        end
        if (wr_last) busy <= 1'b0;
      end
    end
  end

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r10_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(issue_valid));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_last) |=> ($stable(cur_op) && $stable(cur_dst)));
endmodule

// File: rtl/vec_alu_engine.sv
module vec_alu_engine
  import vrf_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int NUM_ELEMS = 8,
  parameter int ELEM_W    = 16,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int IDX_W = $clog2(NUM_ELEMS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  output logic                 issue_ready,
  input  logic [1:0]           issue_op,
  input  logic [REG_W-1:0]     issue_dst,
  input  logic [REG_W-1:0]     issue_src_a,
  input  logic [REG_W-1:0]     issue_src_b,
  input  logic                 fill_valid,
  input  logic [REG_W-1:0]     fill_reg,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic [ELEM_W-1:0]    fill_data,
  output logic                 busy,
  output logic                 done,
  output logic                 wb_valid,
  output logic [IDX_W-1:0]     wb_idx,
  output logic [ELEM_W-1:0]    wb_data,
  output logic [NUM_ELEMS-1:0] mask_out
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEMS - 1);

  logic              accept, rd_vld, wr_last, fill_take, pipe_vld, pipe_eq, bank_we;
  logic [IDX_W-1:0]  rd_idx, pipe_idx, w_idx;
  logic [REG_W-1:0]  cur_dst, cur_src_a, cur_src_b, w_reg;
  logic [ELEM_W-1:0] ra_data, rb_data, pipe_res, w_data;
  vop_e              cur_op, pipe_op;

  vec_seq #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS)) u_seq (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(vop_e'(issue_op)),
    .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
    .wr_last(wr_last), .accept(accept), .busy(busy), .done(done),
    .rd_vld(rd_vld), .rd_idx(rd_idx), .cur_op(cur_op), .cur_dst(cur_dst),
    .cur_src_a(cur_src_a), .cur_src_b(cur_src_b));

  vrf_bank #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ra_reg(cur_src_a), .rb_reg(cur_src_b), .r_idx(rd_idx),
    .ra_data(ra_data), .rb_data(rb_data), .we(bank_we), .w_reg(w_reg),
    .w_idx(w_idx), .w_data(w_data));

  vec_pipe #(.NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(rd_vld), .in_idx(rd_idx), .in_op(cur_op),
    .in_a(ra_data), .in_b(rb_data), .out_vld(pipe_vld), .out_idx(pipe_idx),
    .out_op(pipe_op), .out_res(pipe_res), .out_eq(pipe_eq));

  assign wr_last   = pipe_vld && pipe_idx == LAST_IDX;
  assign wb_valid  = pipe_vld && pipe_op != VOP_CMP;
  assign wb_idx    = pipe_idx;
  assign wb_data   = pipe_res;
  assign fill_take = fill_valid && !busy;

  // single write port: the pipeline owns it while busy, the fill path otherwise
  assign bank_we = wb_valid || fill_take;
  assign w_reg   = wb_valid ? cur_dst  : fill_reg;
  assign w_idx   = wb_valid ? pipe_idx : fill_idx;
  assign w_data  = wb_valid ? pipe_res : fill_data;

  assign issue_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_out <= '0;
    end else if (accept && vop_e'(issue_op) == VOP_CMP) begin
      mask_out <= '0;
    end else if (pipe_vld && pipe_op == VOP_CMP) begin
      mask_out[pipe_idx] <= pipe_eq;
    end
  end

  a_r6_wb_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_idx != LAST_IDX) |=> (wb_valid && wb_idx == IDX_W'($past(wb_idx) + 1'b1)));
  a_r6_wb_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op == VOP_CMP) |-> !wb_valid);
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op != VOP_CMP) |=> $stable(mask_out));
  a_r10_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fill_valid && !wb_valid) |-> !bank_we);
endmodule

// File: tb/test_vec_alu_engine.sv
module test_vec_alu_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0, issue_ready;
  logic [1:0]  issue_op = '0;
  logic [2:0]  issue_dst = '0, issue_src_a = '0, issue_src_b = '0;
  logic        fill_valid = 1'b0;
  logic [2:0]  fill_reg = '0, fill_idx = '0;
  logic [15:0] fill_data = '0;
  logic        busy, done, wb_valid;
  logic [2:0]  wb_idx;
  logic [15:0] wb_data;
  logic [7:0]  mask_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] sh [8][8];
  logic [7:0]  sh_mask = '0;

  always #10 clk = ~clk;

  vec_alu_engine i_vec_alu_engine (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_op(issue_op), .issue_dst(issue_dst), .issue_src_a(issue_src_a),
    .issue_src_b(issue_src_b), .fill_valid(fill_valid), .fill_reg(fill_reg),
    .fill_idx(fill_idx), .fill_data(fill_data), .busy(busy), .done(done),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .mask_out(mask_out));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fill(input int r, input int e, input logic [15:0] d);
    @(negedge clk);
    fill_valid = 1; fill_reg = 3'(r); fill_idx = 3'(e); fill_data = d;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
    sh[r][e] = d;
  endtask

  // expected element value, restated from R3..R5
  function automatic logic [15:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
    logic [31:0] w;
    case (op)
      0: w = {16'h0, a} + {16'h0, b};
      1: w = {16'h0, a} + {16'h0, ~b} + 32'd1;
      default: w = {16'h0, a} * {16'h0, b};
    endcase
    return w[15:0];
  endfunction

  task automatic run_op(input int op, input int d, input int a, input int b,
                        input string req, input bit poke);
    logic [15:0] exp [8];
    logic [7:0]  emask = '0;
    string tag;
    for (int k = 0; k < 8; k++) begin
      exp[k] = model(op, sh[a][k], sh[b][k]);
      emask[k] = (sh[a][k] == sh[b][k]);
    end
    @(negedge clk);
    chk(issue_ready === 1'b1, "R7 ready before issue", issue_ready, 1);
    issue_valid = 1; issue_op = 2'(op); issue_dst = 3'(d);
    issue_src_a = 3'(a); issue_src_b = 3'(b);
    for (int n = 0; n <= 12; n++) begin
      if (n > 0) @(posedge clk); else @(posedge clk);
      @(negedge clk);
      if (n == 0) issue_valid = 0;
      if (poke && n == 4) begin
        issue_valid = 1; issue_op = 2'd0; issue_dst = 3'd5;
        issue_src_a = 3'd0; issue_src_b = 3'd0;
        fill_valid = 1; fill_reg = 3'd5; fill_idx = 3'd2; fill_data = 16'hBEEF;
      end
      if (poke && n == 6) begin issue_valid = 0; fill_valid = 0; end
      tag = $sformatf("%s n=%0d", req, n);
      if (op != 3 && n >= 3 && n <= 10) begin
        chk(wb_valid === 1'b1, {"R6 wb_valid ", tag}, wb_valid, 1);
        chk(wb_idx === 3'(n - 3), {"R6 wb_idx ", tag}, wb_idx, n - 3);
        chk(wb_data === exp[n - 3], {tag, " data"}, wb_data, exp[n - 3]);
      end else begin
        chk(wb_valid === 1'b0, {"R6 R8 wb idle ", tag}, wb_valid, 0);
      end
      chk(done === (n == 11), {"R7 done ", tag}, done, n == 11);
      chk(busy === (n <= 10), {"R7 R10 busy ", tag}, busy, n <= 10);
      chk(issue_ready === (n > 10), {"R7 ready ", tag}, issue_ready, n > 10);
    end
    if (op == 3) begin
      chk(mask_out === emask, {"R8 mask ", req}, mask_out, emask);
      sh_mask = emask;
    end else begin
      chk(mask_out === sh_mask, {"R9 mask held ", req}, mask_out, sh_mask);
      for (int k = 0; k < 8; k++) sh[d][k] = exp[k];
    end
  endtask

  // read register r back: in-place sum with the all-zero register 7
  task automatic read_back(input int r, input string req);
    run_op(0, r, r, 7, req, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) for (int e = 0; e < 8; e++) sh[r][e] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(busy === 0, "R1 busy", busy, 0);
    chk(done === 0, "R1 done", done, 0);
    chk(wb_valid === 0, "R1 wb_valid", wb_valid, 0);
    chk(issue_ready === 1, "R1 ready", issue_ready, 1);
    chk(mask_out === 0, "R1 mask", mask_out, 0);
    read_back(3, "R1 zero contents");

    // R2 fill two source vectors with boundary values
    begin
      logic [15:0] va [8] = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h1234, 16'h0100, 16'h00FF, 16'h0000};
      logic [15:0] vb [8] = '{16'h0001, 16'h8000, 16'h0002, 16'h0003, 16'h1234, 16'h0100, 16'h0101, 16'hFFFF};
      for (int k = 0; k < 8; k++) begin fill(0, k, va[k]); fill(1, k, vb[k]); end
    end
    read_back(0, "R2 fill readback");

    run_op(0, 2, 0, 1, "R3 sum", 0);
    run_op(1, 3, 0, 1, "R4 difference", 0);
    run_op(1, 4, 1, 0, "R4 reversed difference", 0);
    run_op(2, 5, 0, 1, "R5 product", 0);
    run_op(3, 6, 0, 1, "R8 compare mixed", 0);
    read_back(6, "R8 compare leaves dst");
    run_op(3, 6, 4, 4, "R8 compare self", 0);
    run_op(2, 2, 2, 0, "R9 R11 in-place product", 0);
    run_op(1, 1, 1, 1, "R11 self difference", 0);
    run_op(0, 4, 0, 1, "R10 busy poke", 1);
    read_back(5, "R10 fill and issue blocked");
    repeat (3) begin
      @(negedge clk);
      chk(busy === 0, "R10 no second start", busy, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule